// File: doc/BRIEF.md
# Chained Buffer DMA Channel

This block holds the register file and the completion logic for one device-to-memory DMA channel. Software sets up a current pointer, a limit, a start/stop pair for the next buffer and an optional initial-buffer pointer through a 32-bit register port, and drives the channel with command bits written to its control/status register. The memory bus master and the data path sit outside the block.

When the attached device signals that it has written a block of bytes, the channel, if enabled, pads the byte count up to the alignment granule and works out the memory base address. It issues a one-cycle write-request descriptor carrying that address and the padded length. It saves the old current pointer and the end of the block. Unless the chaining-update bit is set, it reloads current and limit from start and stop so that the next block lands in the next buffer. It then sets the completion flag and pulses an interrupt.

Top module: `dma_chain_channel`

## Requirements
- R1: After synchronous reset, every pointer, saved value and CSR bit reads as zero, and `wr_req` and `irq` are low.
- R2: A CSR write (offset 0x0) is a set of commands: bit0 sets DIR, bit1 sets ENABLE, bit2 sets UPDATE, bit3 clears COMPLETE. A zero bit leaves its flag unchanged. A CSR read returns DIR in bit0, ENABLE in bit1, UPDATE in bit2, COMPLETE in bit3 and zero above.
- R3: CSR command bit4 clears DIR, ENABLE, UPDATE and COMPLETE. It overrides any set bits in the same write.
- R4: The current pointer (0x4000), limit (0x4004), start (0x4008), stop (0x400C) and initial-buffer pointer (0x4200) are writable and read back. The saved-next (0x4010) and saved-limit (0x4014) values are read-only.
- R5: A port access is accepted only when `reg_size` is 4. Other sizes neither write nor return data (the read is zero). Unmapped offsets read as zero and ignore writes.
- R6: The padded length is the device count rounded up to a multiple of 16 bytes, or of 32 bytes when `WIDE_ALIGN` is 1. A count of zero gives zero.
- R7: The request address is the initial-buffer pointer when it is nonzero, and the current pointer otherwise. The initial-buffer pointer is zero after every completed block.
- R8: On completion, saved-limit becomes the old current pointer plus the padded length, and saved-next becomes the current pointer as it was before any reload.
- R9: On completion with UPDATE clear, current is loaded from start and limit from stop. With UPDATE set, both keep their values.
- R10: A completion is a `dev_done` strobe while ENABLE is set. On the next clock edge it produces a one-cycle `wr_req` and a one-cycle `irq`, and it sets COMPLETE.
- R11: A `dev_done` strobe while ENABLE is clear is dropped. It produces no request and no interrupt, and it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 16 | Byte offset of the register |
| reg_size | input | 3 | Access size in bytes; only 4 is accepted |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| dev_done | input | 1 | Device reports a block written |
| dev_count | input | 16 | Byte count of that block |
| wr_req | output | 1 | One-cycle write-request descriptor valid |
| wr_addr | output | 32 | Descriptor base address |
| wr_len | output | 17 | Descriptor padded length in bytes |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The hardest condition to reach from the ports is a completion that combines a nonzero initial-buffer pointer, UPDATE set or clear, and a count that sits just above or just below an alignment boundary. Each of these must hold at the same time as the strobe. The random phase therefore interleaves CSR command writes, pointer writes (some of which leave the initial-buffer pointer nonzero) and done strobes whose counts are often chosen near multiples of the granule. A reference model predicts every register after each step. Directed cases cover the 0, 16, 17 and 65535 counts, strobes while disabled, and a reset command combined with set bits.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    localparam int DW    = 32;
    localparam int AW    = 16;
    localparam int CNT_W = 16;
    localparam int LEN_W = CNT_W + 1;

    localparam logic [AW-1:0] OFS_CSR   = 16'h0000;
    localparam logic [AW-1:0] OFS_CUR   = 16'h4000;
    localparam logic [AW-1:0] OFS_LIM   = 16'h4004;
    localparam logic [AW-1:0] OFS_START = 16'h4008;
    localparam logic [AW-1:0] OFS_STOP  = 16'h400C;
    localparam logic [AW-1:0] OFS_SNEXT = 16'h4010;
    localparam logic [AW-1:0] OFS_SLIM  = 16'h4014;
    localparam logic [AW-1:0] OFS_INIT  = 16'h4200;

    localparam int CMD_DIR = 0;
    localparam int CMD_EN  = 1;
    localparam int CMD_UPD = 2;
    localparam int CMD_CLR = 3;
    localparam int CMD_RST = 4;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CSR, SEL_CUR, SEL_LIM, SEL_START,
        SEL_STOP, SEL_SNEXT, SEL_SLIM, SEL_INIT
    } reg_sel_e;

    typedef struct packed {
        logic cmp;
        logic upd;
        logic en;
        logic dir;
    } csr_t;

    typedef struct packed {
        logic [DW-1:0]    addr;
        logic [LEN_W-1:0] len;
    } wr_desc_t;

    function automatic reg_sel_e decode(input logic [AW-1:0] a);
        case (a)
            OFS_CSR:   decode = SEL_CSR;
            OFS_CUR:   decode = SEL_CUR;
            OFS_LIM:   decode = SEL_LIM;
            OFS_START: decode = SEL_START;
            OFS_STOP:  decode = SEL_STOP;
            OFS_SNEXT: decode = SEL_SNEXT;
            OFS_SLIM:  decode = SEL_SLIM;
            OFS_INIT:  decode = SEL_INIT;
            default:   decode = SEL_NONE;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] pad_len(input logic [CNT_W-1:0] cnt,
                                                 input int lg);
        logic [LEN_W-1:0] mask;
        mask    = (LEN_W'(1) << lg) - LEN_W'(1);
        pad_len = ({1'b0, cnt} + mask) & ~mask;
    endfunction

endpackage

// File: rtl/dma_csr_ctl.sv
module dma_csr_ctl
    import dma_chain_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic [4:0] cmd,
    input  logic       set_cmp,
    output csr_t       csr
);
    csr_t nxt;

    always_comb begin
        nxt = csr;
        if (cmd_wr) begin
            if (cmd[CMD_DIR]) nxt.dir = 1'b1;
            if (cmd[CMD_EN])  nxt.en  = 1'b1;
            if (cmd[CMD_UPD]) nxt.upd = 1'b1;
            if (cmd[CMD_CLR]) nxt.cmp = 1'b0;
            if (cmd[CMD_RST]) nxt = '0;
        end
        if (set_cmp) nxt.cmp = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) csr <= '0;
        else     csr <= nxt;
    end
endmodule

// File: rtl/dma_ptr_bank.sv
module dma_ptr_bank
    import dma_chain_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_wr,
    input  reg_sel_e         sw_sel,
    input  logic [DW-1:0]    sw_data,
    input  logic             fire,
    input  logic [LEN_W-1:0] plen,
    input  logic             keep,
    output logic [DW-1:0]    cur,
    output logic [DW-1:0]    lim,
    output logic [DW-1:0]    start,
    output logic [DW-1:0]    stop,
    output logic [DW-1:0]    init,
    output logic [DW-1:0]    snext,
    output logic [DW-1:0]    slim
);
    // start/stop share one shape: plain software-written words
    localparam int NPLAIN = 2;
    localparam reg_sel_e PLAIN_SEL [NPLAIN] = '{SEL_START, SEL_STOP};
    logic [DW-1:0] plain [NPLAIN];

    for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
        always_ff @(posedge clk) begin
            if (rst)                                  plain[g] <= '0;
            else if (sw_wr && sw_sel == PLAIN_SEL[g]) plain[g] <= sw_data;
        end
    end
    assign start = plain[0];
    assign stop  = plain[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            lim   <= '0;
            init  <= '0;
            snext <= '0;
            slim  <= '0;
        end else begin
            if (sw_wr && sw_sel == SEL_CUR)  cur  <= sw_data;
            if (sw_wr && sw_sel == SEL_LIM)  lim  <= sw_data;
            if (sw_wr && sw_sel == SEL_INIT) init <= sw_data;
            if (fire) begin
                snext <= cur;
                slim  <= cur + DW'(plen);
                init  <= '0;
                if (!keep) begin
                    cur <= start;
                    lim <= stop;
                end
            end
        end
    end
endmodule

// File: rtl/dma_done_engine.sv
module dma_done_engine
    import dma_chain_pkg::*;
#(
    parameter int ALIGN_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  logic [CNT_W-1:0] count,
    input  logic             enabled,
    input  logic [DW-1:0]    init,
    input  logic [DW-1:0]    cur,
    output logic             fire,
    output logic [LEN_W-1:0] plen,
    output wr_desc_t         desc,
    output logic             req,
    output logic             pulse
);
    assign fire = done & enabled;
    assign plen = pad_len(count, ALIGN_LOG2);

    always_ff @(posedge clk) begin
        if (rst) begin
            desc  <= '0;
            req   <= 1'b0;
            pulse <= 1'b0;
        end else begin
            req   <= fire;
            pulse <= fire;
            if (fire) begin
                desc.addr <= (init != '0) ? init : cur;
                desc.len  <= plen;
            end
        end
    end
endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
    import dma_chain_pkg::*;
#(
    parameter bit WIDE_ALIGN = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_en,
    input  logic        reg_we,
    input  logic [15:0] reg_addr,
    input  logic [2:0]  reg_size,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        dev_done,
    input  logic [15:0] dev_count,
    output logic        wr_req,
    output logic [31:0] wr_addr,
    output logic [16:0] wr_len,
    output logic        irq
);
    localparam int ALIGN_LOG2 = WIDE_ALIGN ? 5 : 4;

    reg_sel_e      sel;
    logic          acc_ok, sw_wr;
    csr_t          csr;
    logic          csr_en, csr_cmp;
    logic          fire;
    logic [LEN_W-1:0] plen;
    wr_desc_t      desc;
    logic [DW-1:0] cur, lim, start, stop, init, snext, slim;

    assign sel     = decode(reg_addr);
    assign acc_ok  = reg_en && (reg_size == 3'd4);
    assign sw_wr   = acc_ok && reg_we;
    assign csr_en  = csr.en;
    assign csr_cmp = csr.cmp;

    dma_csr_ctl u_csr (
        .clk     (clk),
        .rst     (rst),
        .cmd_wr  (sw_wr && sel == SEL_CSR),
        .cmd     (reg_wdata[4:0]),
        .set_cmp (fire),
        .csr     (csr)
    );

    dma_done_engine #(.ALIGN_LOG2(ALIGN_LOG2)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .done    (dev_done),
        .count   (dev_count),
        .enabled (csr.en),
        .init    (init),
        .cur     (cur),
        .fire    (fire),
        .plen    (plen),
        .desc    (desc),
        .req     (wr_req),
        .pulse   (irq)
    );

    dma_ptr_bank u_ptr (
        .clk     (clk),
        .rst     (rst),
        .sw_wr   (sw_wr),
        .sw_sel  (sel),
        .sw_data (reg_wdata),
        .fire    (fire),
        .plen    (plen),
        .keep    (csr.upd),
        .cur     (cur),
        .lim     (lim),
        .start   (start),
        .stop    (stop),
        .init    (init),
        .snext   (snext),
        .slim    (slim)
    );

    assign wr_addr = desc.addr;
    assign wr_len  = desc.len;

    always_comb begin
        reg_rdata = '0;
        if (acc_ok && !reg_we) begin
            case (sel)
                SEL_CSR:   reg_rdata = {28'b0, csr};
                SEL_CUR:   reg_rdata = cur;
                SEL_LIM:   reg_rdata = lim;
                SEL_START: reg_rdata = start;
                SEL_STOP:  reg_rdata = stop;
                SEL_SNEXT: reg_rdata = snext;
                SEL_SLIM:  reg_rdata = slim;
                SEL_INIT:  reg_rdata = init;
                default:   reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk #(
    parameter int ALIGN_LOG2 = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        dev_done,
    input logic [15:0] dev_count,
    input logic        wr_req,
    input logic [16:0] wr_len,
    input logic        irq,
    input logic        st_en,
    input logic        st_cmp
);
    // R10
    done_fires_chk: assert property (@(posedge clk) disable iff (rst)
        dev_done && st_en |=> irq && wr_req && st_cmp);

    // R11
    drop_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        dev_done && !st_en |=> !irq && !wr_req);

    // R10
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(dev_done) && $past(st_en));

    // R6
    len_granule_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> wr_len[ALIGN_LOG2-1:0] == '0);

    // R6
    len_cover_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> (wr_len >= {1'b0, $past(dev_count)}) &&
                   (wr_len < {1'b0, $past(dev_count)} + (17'd1 << ALIGN_LOG2)));
endmodule

bind dma_chain_channel dma_chain_chk #(.ALIGN_LOG2(ALIGN_LOG2)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dev_done  (dev_done),
    .dev_count (dev_count),
    .wr_req    (wr_req),
    .wr_len    (wr_len),
    .irq       (irq),
    .st_en     (csr_en),
    .st_cmp    (csr_cmp)
);

// File: tb/sim_dma_chain_channel.sv
module sim_dma_chain_channel;
    localparam int CLK_PERIOD = 10;
    localparam int LG = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [2:0]  reg_size = 3'd4;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_done = 1'b0;
    logic [15:0] dev_count = '0;
    logic        wr_req, irq;
    logic [31:0] wr_addr;
    logic [16:0] wr_len;

    int total = 0, bad = 0;
    bit finished = 0;

    // reference state
    logic [31:0] m_cur, m_lim, m_start, m_stop, m_init, m_snext, m_slim;
    logic m_dir, m_en, m_upd, m_cmp;

    dma_chain_channel u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [16:0] exp_pad(input logic [15:0] c);
        logic [16:0] m;
        m = (17'd1 << LG) - 17'd1;
        return ({1'b0, c} + m) & ~m;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        {m_cur, m_lim, m_start, m_stop, m_init, m_snext, m_slim} = '0;
        {m_dir, m_en, m_upd, m_cmp} = '0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [2:0] sz);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d; reg_size = sz;
        @(negedge clk);
        reg_en = 0; reg_we = 0; reg_size = 3'd4;
        if (sz == 3'd4) begin
            case (a)
                16'h0000: begin
                    if (d[0]) m_dir = 1;
                    if (d[1]) m_en = 1;
                    if (d[2]) m_upd = 1;
                    if (d[3]) m_cmp = 0;
                    if (d[4]) {m_dir, m_en, m_upd, m_cmp} = '0;
                end
                16'h4000: m_cur = d;
                16'h4004: m_lim = d;
                16'h4008: m_start = d;
                16'h400C: m_stop = d;
                16'h4200: m_init = d;
                default: ;
            endcase
        end
    endtask

    task automatic rd(input logic [15:0] a, input logic [2:0] sz, output logic [31:0] d);
        reg_en = 1; reg_we = 0; reg_addr = a; reg_size = sz;
        #1 d = reg_rdata;
        reg_en = 0; reg_size = 3'd4;
    endtask

    task automatic check_regs(input string tag);
        logic [31:0] d;
        @(negedge clk);
        rd(16'h0000, 3'd4, d); chk({tag, " R2 csr"}, d, {28'b0, m_cmp, m_upd, m_en, m_dir});
        rd(16'h4000, 3'd4, d); chk({tag, " R4/R9 cur"}, d, m_cur);
        rd(16'h4004, 3'd4, d); chk({tag, " R4/R9 lim"}, d, m_lim);
        rd(16'h4008, 3'd4, d); chk({tag, " R4 start"}, d, m_start);
        rd(16'h400C, 3'd4, d); chk({tag, " R4 stop"}, d, m_stop);
        rd(16'h4200, 3'd4, d); chk({tag, " R4/R7 init"}, d, m_init);
        rd(16'h4010, 3'd4, d); chk({tag, " R8 snext"}, d, m_snext);
        rd(16'h4014, 3'd4, d); chk({tag, " R8 slim"}, d, m_slim);
    endtask

    task automatic done(input logic [15:0] c);
        logic [31:0] e_addr;
        logic [16:0] e_len;
        bit fire;
        @(negedge clk);
        dev_done = 1; dev_count = c;
        fire = m_en;
        e_len = exp_pad(c);
        e_addr = (m_init != 0) ? m_init : m_cur;
        @(negedge clk);
        dev_done = 0;
        chk("R10/R11 wr_req", {31'b0, wr_req}, {31'b0, fire});
        chk("R10/R11 irq", {31'b0, irq}, {31'b0, fire});
        if (fire) begin
            chk("R7 wr_addr", wr_addr, e_addr);
            chk("R6 wr_len", {15'b0, wr_len}, {15'b0, e_len});
            m_snext = m_cur;
            m_slim = m_cur + {15'b0, e_len};
            m_init = 0;
            if (!m_upd) begin m_cur = m_start; m_lim = m_stop; end
            m_cmp = 1;
        end
        @(negedge clk);
        chk("R10 irq one cycle", {31'b0, irq}, 32'd0);
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 wr_req", {31'b0, wr_req}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        check_regs("R1");

        // R11 dropped while disabled
        wr(16'h4000, 32'h1000_0000, 3'd4);
        done(16'd40);
        check_regs("R11");

        // R2/R3 commands
        wr(16'h0000, 32'h7, 3'd4);
        check_regs("R2 set");
        wr(16'h0000, 32'h17, 3'd4);
        check_regs("R3 reset wins");

        // R5 size and unmapped
        wr(16'h4008, 32'hDEAD_BEEF, 3'd2);
        wr(16'h4100, 32'h1234_5678, 3'd4);
        @(negedge clk);
        rd(16'h4000, 3'd1, d); chk("R5 bad size read", d, 0);
        rd(16'h4100, 3'd4, d); chk("R5 unmapped read", d, 0);
        check_regs("R5");

        // directed pad corners, R6/R7/R8/R9
        wr(16'h4008, 32'h2000_0000, 3'd4);
        wr(16'h400C, 32'h2000_1000, 3'd4);
        wr(16'h0000, 32'h2, 3'd4);
        done(16'd0);  check_regs("R6 zero");
        done(16'd16); check_regs("R6 exact");
        done(16'd17); check_regs("R6 up");
        wr(16'h4200, 32'h3000_0040, 3'd4);
        done(16'd65535); check_regs("R7 init");
        wr(16'h0000, 32'h4, 3'd4);
        wr(16'h4000, 32'h4000_0000, 3'd4);
        done(16'd100); check_regs("R9 keep");
        wr(16'h0000, 32'h8, 3'd4);
        check_regs("R2 clear cmp");

        // random phase
        for (int i = 0; i < 300; i++) begin
            int k;
            k = $urandom_range(0, 9);
            case (k)
                0: wr(16'h0000, $urandom_range(0, 31), 3'd4);
                1: wr(16'h0000, 32'h2, 3'd4);
                2: wr(16'h4000, $urandom, 3'd4);
                3: wr(16'h4008, $urandom, 3'd4);
                4: wr(16'h400C, $urandom, 3'd4);
                5: wr(16'h4200, ($urandom_range(0, 1) == 0) ? 32'h0 : $urandom, 3'd4);
                6: wr(16'h4004, $urandom, 3'($urandom_range(0, 7)));
                7: wr(16'h4010, $urandom, 3'd4);
                default: begin
                    int b;
                    b = $urandom_range(0, 4095) * 16;
                    done(16'(b + $urandom_range(0, 2) - 1));
                end
            endcase
            check_regs("rand");
        end

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule